// File: doc/BRIEF.md
# Program Status Poll Responder

This block builds the byte returned to a reader of a nonvolatile array while an internal program cycle may be running. When the array is idle it passes the normal array read data through untouched. While a program cycle is running, the read data carries two independent end-of-cycle indications. The first is bit 7, which is the complement of bit 7 of the byte loaded last. The second is bit 6, which flips value on every new read, whichever location the read targets.

A controller polls either bit until the indication clears. For bit 7, the byte read back matches the loaded data again. For bit 6, two successive reads return the same value. Polling can start at any point in the cycle.

The busy input comes from the surrounding write logic. It is held high for the whole program cycle. It is also held high for the write cycle time after a write that carried no valid unlock sequence, so reads made in that window behave as polls as well. Output-enable timing and bus tri-state control sit outside this block.

The controller has two states:
- ST_IDLE: the byte is passed through unchanged.
- ST_BUSY: the status byte is returned.

It has two transitions, both taken at a clock edge:
- START: ST_IDLE to ST_BUSY, taken when busy is sampled high.
- DONE: ST_BUSY to ST_IDLE, taken when busy is sampled low.

A read is counted at the rising edge of the read strobe. The toggle flip-flop advances on such an edge only while in ST_BUSY.

Top module: `poll_status_responder`

## Requirements
- R1: Out of reset, with busy low, the block is in ST_IDLE and rd_data equals array_data.
- R2: In ST_IDLE all eight bits of rd_data follow array_data combinationally, whatever the read strobe does.
- R3: From the first clock edge that samples busy high, rd_data bit 7 is the complement of last_data bit 7 for as long as the block stays in ST_BUSY.
- R4: In ST_BUSY, rd_data bit 6 holds a different value after each read strobe rising edge than it held before it. A read strobe rising edge is a low-to-high change seen at a clock edge. This holds regardless of array_data.
- R5: In ST_BUSY, rd_data bit 6 keeps its value while the read strobe stays high or stays low. A strobe that was already high when the block entered ST_BUSY does not count as a new read.
- R6: In ST_BUSY, rd_data bits 5 down to 0 equal last_data bits 5 down to 0.
- R7: From the first clock edge that samples busy low, the block is in ST_IDLE. All eight bits of rd_data then equal array_data, and further reads no longer change bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy | input | 1 | High while a program cycle or write recovery window is running |
| rd_strobe | input | 1 | Read strobe; a rising edge counts as one read |
| last_data | input | 8 | Byte loaded last into the program buffer |
| array_data | input | 8 | Normal array read data |
| rd_data | output | 8 | Byte returned to the reader |

## Verification
The assertions take for granted that busy, rd_strobe and both data inputs are synchronous to clk. They also take for granted that these inputs hold known values from reset onward, so that the previous-cycle comparisons on busy and the toggle flip-flop are meaningful. The stimulus changes every input only on the falling clock edge, holds busy and rd_strobe at zero through reset, and keeps each strobe pulse at least one full clock high and one full clock low. As a result, each read is seen as exactly one rising edge.

// File: rtl/poll_pkg.sv
package poll_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } poll_state_e;

    localparam int DATA_W_DEF     = 8;
    localparam int POLL_BIT_DEF   = 7;
    localparam int TOGGLE_BIT_DEF = 6;

endpackage

// File: rtl/poll_strobe_edge.sv
module poll_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise
);

    logic strobe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= strobe;
        end
    end

    assign rise = strobe & ~strobe_q;

    // R4 / R5: a single read produces exactly one edge
    assert_single_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/poll_toggle.sv
module poll_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    output logic tog
);

    logic tog_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else if (advance) begin
            tog_q <= ~tog_q;
        end
    end

    assign tog = tog_q;

    assert_toggle_flips_R4: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (tog_q != $past(tog_q)));

    assert_toggle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(tog_q));

endmodule

// File: rtl/poll_data_mux.sv
module poll_data_mux #(
    parameter int DATA_W     = 8,
    parameter int POLL_BIT   = 7,
    parameter int TOGGLE_BIT = 6
) (
    input  poll_pkg::poll_state_e state,
    input  logic                  tog,
    input  logic [DATA_W-1:0]     last_data,
    input  logic [DATA_W-1:0]     array_data,
    output logic [DATA_W-1:0]     rd_data
);

    logic [DATA_W-1:0] status_byte;

    for (genvar i = 0; i < DATA_W; i++) begin : g_status
        if (i == POLL_BIT) begin : g_poll
            assign status_byte[i] = ~last_data[i];
        end else if (i == TOGGLE_BIT) begin : g_tog
            assign status_byte[i] = tog;
        end else begin : g_fill
            assign status_byte[i] = last_data[i];
        end
    end

    always_comb begin
        unique case (state)
            poll_pkg::ST_IDLE: rd_data = array_data;
            poll_pkg::ST_BUSY: rd_data = status_byte;
            default:           rd_data = array_data;
        endcase
    end

endmodule

// File: rtl/poll_status_responder.sv
module poll_status_responder #(
    parameter int DATA_W     = poll_pkg::DATA_W_DEF,
    parameter int POLL_BIT   = poll_pkg::POLL_BIT_DEF,
    parameter int TOGGLE_BIT = poll_pkg::TOGGLE_BIT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              rd_strobe,
    input  logic [DATA_W-1:0] last_data,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data
);
    import poll_pkg::*;

    localparam int FILL_HI = TOGGLE_BIT - 1;

    poll_state_e state_q, state_d;
    logic        rd_rise;
    logic        tog_adv;
    logic        tog;

    // next-state logic: START and DONE transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (busy)  state_d = ST_BUSY;   // START
            ST_BUSY: if (!busy) state_d = ST_IDLE;   // DONE
            default:            state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    poll_strobe_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (rd_strobe),
        .rise   (rd_rise)
    );

    assign tog_adv = rd_rise && (state_q == ST_BUSY);

    poll_toggle u_toggle (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (tog_adv),
        .tog     (tog)
    );

    // output process
    poll_data_mux #(
        .DATA_W     (DATA_W),
        .POLL_BIT   (POLL_BIT),
        .TOGGLE_BIT (TOGGLE_BIT)
    ) u_mux (
        .state      (state_q),
        .tog        (tog),
        .last_data  (last_data),
        .array_data (array_data),
        .rd_data    (rd_data)
    );

    assert_start_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (state_q == ST_BUSY));

    assert_done_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (state_q == ST_IDLE));

    assert_poll_inverted_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY) |-> (rd_data[POLL_BIT] != last_data[POLL_BIT]));

    assert_fill_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY) |-> (rd_data[FILL_HI:0] == last_data[FILL_HI:0]));

    assert_idle_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> (rd_data == array_data));

endmodule

// File: tb/test_poll_status_responder.sv
module test_poll_status_responder;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       busy;
    logic       rd_strobe;
    logic [7:0] last_data;
    logic [7:0] array_data;
    logic [7:0] rd_data;

    int checks   = 0;
    int failures = 0;

    always #5 clk = ~clk;

    poll_status_responder i_poll_status_responder (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .rd_strobe  (rd_strobe),
        .last_data  (last_data),
        .array_data (array_data),
        .rd_data    (rd_data)
    );

    task automatic check_byte(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic do_read(output logic [7:0] v);
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) v = rd_data;
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic enter_busy(input logic [7:0] ld);
        @(negedge clk) begin busy = 1'b1; last_data = ld; end
        @(negedge clk);
    endtask

    task automatic leave_busy();
        @(negedge clk) busy = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; busy = 1'b0; rd_strobe = 1'b0;
        last_data = 8'h00; array_data = 8'h3C;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_byte("R1 reset pass-through", rd_data, 8'h3C);
    endtask

    task automatic t_idle_pass();
        logic [7:0] v;
        logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
        foreach (pats[k]) begin
            @(negedge clk) array_data = pats[k];
            #1 check_byte("R2 idle pass-through", rd_data, pats[k]);
        end
        array_data = 8'h96;
        do_read(v);
        check_byte("R2 idle read with strobe", v, 8'h96);
    endtask

    task automatic t_poll_bit();
        logic [7:0] v;
        array_data = 8'h11;
        enter_busy(8'hB5);
        check_bit("R3 bit7 inverted (last=B5)", rd_data[7], 1'b0);
        check_byte("R6 low bits (last=B5)", {2'b00, rd_data[5:0]}, 8'h35);
        leave_busy();
        enter_busy(8'h2A);
        do_read(v);
        check_bit("R3 bit7 inverted (last=2A)", v[7], 1'b1);
        check_byte("R6 low bits (last=2A)", {2'b00, v[5:0]}, 8'h2A);
        leave_busy();
    endtask

    task automatic t_toggle();
        logic [7:0] a, b, c;
        enter_busy(8'h7E);
        array_data = 8'h00;
        do_read(a);
        array_data = 8'hFF;
        do_read(b);
        array_data = 8'h5A;
        do_read(c);
        check_bit("R4 toggle differs read1->read2", b[6], ~a[6]);
        check_bit("R4 toggle differs read2->read3", c[6], ~b[6]);
        leave_busy();
    endtask

    task automatic t_toggle_hold();
        logic first;
        // strobe already high across entry into busy
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) begin busy = 1'b1; last_data = 8'h00; end
        @(negedge clk) first = rd_data[6];
        repeat (3) @(negedge clk);
        check_bit("R5 strobe held high across entry", rd_data[6], first);
        rd_strobe = 1'b0;
        repeat (4) @(negedge clk);
        check_bit("R5 strobe held low", rd_data[6], first);
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) check_bit("R4 new edge after hold", rd_data[6], ~first);
        repeat (3) @(negedge clk);
        check_bit("R5 strobe held high after edge", rd_data[6], ~first);
        rd_strobe = 1'b0;
        leave_busy();
    endtask

    task automatic t_complete();
        logic [7:0] v1, v2;
        array_data = 8'hC3;
        enter_busy(8'h80);
        do_read(v1);
        @(negedge clk) busy = 1'b0;
        @(negedge clk) check_byte("R7 true data after done", rd_data, 8'hC3);
        array_data = 8'h40;
        do_read(v1);
        do_read(v2);
        check_byte("R7 read1 after done", v1, 8'h40);
        check_byte("R7 read2 after done (bit6 steady)", v2, 8'h40);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_idle_pass();
        t_poll_bit();
        t_toggle();
        t_toggle_hold();
        t_complete();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule